// File: doc/BRIEF.md
# Register-Driven SPI Command Engine

This block lets a host issue short SPI flash commands through a small window of byte-wide registers. The host loads a control byte, an opcode and up to three trailing bytes. It then rewrites the control byte with its launch bit set. The engine drives chip select low and shifts the opcode and the trailing bytes out. It clocks in any requested response bytes and raises chip select again. The launch bit reads as a busy flag until the whole frame is over.

The same control byte carries the byte counts and a three-bit command class. Class 010 marks read-type commands such as identification and data reads. Class 011 marks a status-register write, and class 101 marks erasures. The class is stored and read back for the host's own use, and it does not change the shifting. Responses land in three read-back registers, filled in order. The register window sits at a parameterised base address, 0x60 by default. All offsets below are relative to that base.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and every register in the window reads 0x00.
- R2: The control register at offset 0 keeps bits 7:1 as written and reads them back. Bit 0 is launch/busy, bits 4:3 give the count of trailing write bytes (0 to 3), bits 2:1 give the count of response bytes (0 to 3), and bits 7:5 are the command class, which has no effect on the frame.
- R3: A write to offset 0 with bit 0 set while idle starts a frame at once. Bit 0 of offset 0 then reads 1 until the frame ends and reads 0 afterwards.
- R4: The frame shifts out, MSB first, the opcode held at offset 1 and then the counted trailing bytes from offsets 4, 5 and 6, in that order. Bytes clocked during the response phase carry 0x00 on the data-out line.
- R5: Response bytes are captured MSB first and stored in order at offsets 7, 8 and 9.
- R6: With a response count of zero the frame has no response cycles: it is exactly 8 x (1 + write count) clock periods long, and offsets 7 to 9 keep their previous contents.
- R7: SPI mode 0 timing with HALF_DIV system clocks per half period. The serial clock idles low and moves only while chip select is low. Chip select falls on the clock edge that accepts the launch write. The first rising edge comes HALF_DIV clocks later, and chip select rises HALF_DIV clocks after the last falling edge.
- R8: While busy, host writes to offsets 0 to 9 are ignored, including a second launch. A read of offset 0 always returns the live busy bit.
- R9: Offsets 7 to 9 ignore host writes. Offsets 2 and 3, and any address outside the window, read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A wrong byte index or a wrong count field shows at once on the serial lines. Chip select or the serial clock moves on a different cycle from the reference timeline, so the mismatch appears in the same clock. A wrong bit order or a wrong capture slot stays hidden until the host reads the response registers after the frame. That is why every command is followed by reading back all three slots, including the ones that must keep older values. A write lock that leaks shows only later, when the opcode, the trailing bytes or the control byte read back changed, or when an extra frame appears on chip select.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

   // sequencer phases
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_SHIFT = 2'd1,
      SEQ_TAIL  = 2'd2
   } seq_state_e;

   // offsets inside the register window (a neighbour decodes these)
   localparam int OFS_CTRL = 0;
   localparam int OFS_OPC  = 1;
   localparam int OFS_XW0  = 4;

   // number of trailing/response slots for a given count-field width
   function automatic int slot_count(input int cnt_w);
      return (1 << cnt_w) - 1;
   endfunction

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
   import spi_cmd_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 'h60,
   parameter int CNT_W = 2,
   localparam int N_SLOT = slot_count(CNT_W)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_we,
   input  logic [7:0]            bus_wdata,
   output logic [7:0]            bus_rdata,
   input  logic                  busy,
   input  logic                  cap_en,
   input  logic [CNT_W-1:0]      cap_idx,
   input  logic [7:0]            cap_data,
   output logic                  start,
   output logic [CNT_W-1:0]      start_wcnt,
   output logic [CNT_W-1:0]      start_rcnt,
   output logic [7:0]            opcode,
   output logic [8*N_SLOT-1:0]   xw_flat,
   output logic [8*N_SLOT-1:0]   rd_flat
);

   localparam int RD0 = OFS_XW0 + N_SLOT;
   localparam int WIN = RD0 + N_SLOT;

   logic [ADDR_W-1:0] rel;
   int                rel_i;
   logic              in_win;
   logic              host_wr;
   logic [7:1]        ctrl_hi_q;
   logic [7:0]        opc_q;

   assign rel     = bus_addr - BASE_ADDR;
   assign rel_i   = int'(rel);
   assign in_win  = (bus_addr >= BASE_ADDR) && (rel_i < WIN);
   assign host_wr = bus_we && !busy && in_win;

   // launch request and the counts it carries
   assign start      = host_wr && (rel_i == OFS_CTRL) && bus_wdata[0];
   assign start_wcnt = bus_wdata[2*CNT_W:CNT_W+1];
   assign start_rcnt = bus_wdata[CNT_W:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_hi_q <= '0;
         opc_q     <= '0;
      end else if (host_wr) begin
         if (rel_i == OFS_CTRL) ctrl_hi_q <= bus_wdata[7:1];
         if (rel_i == OFS_OPC)  opc_q     <= bus_wdata;
      end
   end

   assign opcode = opc_q;

   generate
      for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
         logic [7:0] xw_r;
         logic [7:0] rd_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               xw_r <= '0;
            else if (host_wr && rel_i == OFS_XW0 + i)
               xw_r <= bus_wdata;
         end

         // filled only by the sequencer; host writes never land here
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rd_r <= '0;
            else if (cap_en && int'(cap_idx) == i)
               rd_r <= cap_data;
         end

         assign xw_flat[8*i +: 8] = xw_r;
         assign rd_flat[8*i +: 8] = rd_r;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (in_win) begin
         if (rel_i == OFS_CTRL)
            bus_rdata = {ctrl_hi_q, busy};
         else if (rel_i == OFS_OPC)
            bus_rdata = opc_q;
         else begin
            for (int i = 0; i < N_SLOT; i++) begin
               if (rel_i == OFS_XW0 + i) bus_rdata = xw_flat[8*i +: 8];
               if (rel_i == RD0 + i)     bus_rdata = rd_flat[8*i +: 8];
            end
         end
      end
   end

endmodule

// File: rtl/spi_cmd_tick.sv
module spi_cmd_tick #(
   parameter int HALF_DIV = 2,
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);

   localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!en)
         cnt_q <= '0;
      else if (cnt_q == LAST)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign tick = en && (cnt_q == LAST);

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
   import spi_cmd_pkg::*;
#(
   parameter int CNT_W = 2,
   localparam int N_SLOT = slot_count(CNT_W),
   localparam int IDX_W = $clog2(2*N_SLOT + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [CNT_W-1:0]     start_wcnt,
   input  logic [CNT_W-1:0]     start_rcnt,
   input  logic [7:0]           opcode,
   input  logic [8*N_SLOT-1:0]  xw_flat,
   input  logic                 tick,
   input  logic                 spi_miso,
   output logic                 busy,
   output logic                 spi_sck,
   output logic                 spi_cs_n,
   output logic                 spi_mosi,
   output logic                 cap_en,
   output logic [CNT_W-1:0]     cap_idx,
   output logic [7:0]           cap_data
);

   seq_state_e        state_q;
   logic              sck_q;
   logic              cs_n_q;
   logic [7:0]        tx_q;
   logic [7:0]        rx_q;
   logic [2:0]        bit_q;
   logic [IDX_W-1:0]  idx_q;
   logic [CNT_W-1:0]  wcnt_q;
   logic [CNT_W-1:0]  rcnt_q;

   logic [IDX_W-1:0]  wcnt_x;
   logic [IDX_W-1:0]  last_idx;
   logic [IDX_W-1:0]  next_idx;
   logic [7:0]        next_tx;
   logic              byte_end;
   logic              is_read;

   assign wcnt_x   = IDX_W'(wcnt_q);
   assign last_idx = wcnt_x + IDX_W'(rcnt_q);
   assign next_idx = idx_q + 1'b1;
   assign is_read  = idx_q > wcnt_x;
   assign byte_end = (state_q == SEQ_SHIFT) && tick && sck_q && (bit_q == 3'd7);

   // trailing byte for the next frame position, zero in the response phase
   always_comb begin
      next_tx = '0;
      for (int i = 0; i < N_SLOT; i++) begin
         if ((int'(next_idx) == i + 1) && (next_idx <= wcnt_x))
            next_tx = xw_flat[8*i +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         sck_q   <= 1'b0;
         cs_n_q  <= 1'b1;
         tx_q    <= '0;
         rx_q    <= '0;
         bit_q   <= '0;
         idx_q   <= '0;
         wcnt_q  <= '0;
         rcnt_q  <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  state_q <= SEQ_SHIFT;
                  cs_n_q  <= 1'b0;
                  sck_q   <= 1'b0;
                  tx_q    <= opcode;
                  bit_q   <= '0;
                  idx_q   <= '0;
                  wcnt_q  <= start_wcnt;
                  rcnt_q  <= start_rcnt;
               end
            end
            SEQ_SHIFT: begin
               if (tick) begin
                  if (!sck_q) begin
                     sck_q <= 1'b1;
                     rx_q  <= {rx_q[6:0], spi_miso};
                  end else begin
                     sck_q <= 1'b0;
                     if (bit_q == 3'd7) begin
                        bit_q <= '0;
                        if (idx_q == last_idx) begin
                           state_q <= SEQ_TAIL;
                           tx_q    <= '0;
                        end else begin
                           idx_q <= next_idx;
                           tx_q  <= next_tx;
                        end
                     end else begin
                        bit_q <= bit_q + 1'b1;
                        tx_q  <= {tx_q[6:0], 1'b0};
                     end
                  end
               end
            end
            SEQ_TAIL: begin
               if (tick) begin
                  cs_n_q  <= 1'b1;
                  state_q <= SEQ_IDLE;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != SEQ_IDLE);
   assign spi_sck  = sck_q;
   assign spi_cs_n = cs_n_q;
   assign spi_mosi = tx_q[7];
   assign cap_en   = byte_end && is_read;
   assign cap_data = rx_q;
   assign cap_idx  = CNT_W'(idx_q - wcnt_x - 1'b1);

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
   import spi_cmd_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 'h60,
   parameter int CNT_W = 2,
   parameter int HALF_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              spi_sck,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso
);

   localparam int N_SLOT = slot_count(CNT_W);
   localparam int WIN    = OFS_XW0 + 2*N_SLOT;

   // elaboration-time parameter checks
   generate
      if (2*CNT_W + 1 >= 8) begin : g_bad_cnt
         $error("count fields plus launch bit leave no room for the class field");
      end
      if (HALF_DIV < 1) begin : g_bad_div
         $error("half period must be at least one clock");
      end
      if (int'(BASE_ADDR) + WIN > (1 << ADDR_W)) begin : g_bad_base
         $error("register window does not fit the address space");
      end
   endgenerate

   logic                 start;
   logic [CNT_W-1:0]     start_wcnt;
   logic [CNT_W-1:0]     start_rcnt;
   logic [7:0]           opcode;
   logic [8*N_SLOT-1:0]  xw_flat;
   logic [8*N_SLOT-1:0]  rd_flat;
   logic                 busy;
   logic                 tick;
   logic                 cap_en;
   logic [CNT_W-1:0]     cap_idx;
   logic [7:0]           cap_data;

   spi_cmd_regs #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR),
      .CNT_W     (CNT_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_we     (bus_we),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .busy       (busy),
      .cap_en     (cap_en),
      .cap_idx    (cap_idx),
      .cap_data   (cap_data),
      .start      (start),
      .start_wcnt (start_wcnt),
      .start_rcnt (start_rcnt),
      .opcode     (opcode),
      .xw_flat    (xw_flat),
      .rd_flat    (rd_flat)
   );

   // half-period pacing: a plain enable at full rate, a counter otherwise
   generate
      if (HALF_DIV == 1) begin : g_tick_full
         assign tick = busy;
      end else begin : g_tick_div
         spi_cmd_tick #(
            .HALF_DIV (HALF_DIV)
         ) u_tick (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (busy),
            .tick  (tick)
         );
      end
   endgenerate

   spi_cmd_seq #(
      .CNT_W (CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_wcnt (start_wcnt),
      .start_rcnt (start_rcnt),
      .opcode     (opcode),
      .xw_flat    (xw_flat),
      .tick       (tick),
      .spi_miso   (spi_miso),
      .busy       (busy),
      .spi_sck    (spi_sck),
      .spi_cs_n   (spi_cs_n),
      .spi_mosi   (spi_mosi),
      .cap_en     (cap_en),
      .cap_idx    (cap_idx),
      .cap_data   (cap_data)
   );

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
   parameter int CNT_W = 2,
   localparam int N_SLOT = (1 << CNT_W) - 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                busy,
   input logic                spi_cs_n,
   input logic                spi_sck,
   input logic [7:0]          opcode,
   input logic [8*N_SLOT-1:0] rd_flat
);

   // R7
   sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);

   // R7
   sck_moves_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck != $past(spi_sck)) |-> !spi_cs_n);

   // R3
   cs_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_cs_n |-> busy);

   // R3
   launch_selects_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && !spi_cs_n));

   // R8
   opcode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(opcode));

   // R6
   readback_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_cs_n && $past(spi_cs_n)) |-> $stable(rd_flat));

endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(
   .CNT_W (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .spi_cs_n (spi_cs_n),
   .spi_sck  (spi_sck),
   .opcode   (opcode),
   .rd_flat  (rd_flat)
);

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;

   localparam int HALF = 3;
   localparam logic [7:0] A_CTRL = 8'h60;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] bus_addr;
   logic       bus_we;
   logic [7:0] bus_wdata;
   logic [7:0] bus_rdata;
   logic       spi_sck;
   logic       spi_cs_n;
   logic       spi_mosi;
   logic       spi_miso;

   always #2 clk = ~clk;

   spi_cmd_engine #(.HALF_DIV(HALF)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .spi_sck   (spi_sck),
      .spi_cs_n  (spi_cs_n),
      .spi_mosi  (spi_mosi),
      .spi_miso  (spi_miso)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int seed, input int k);
      return 8'((seed * 37 + k * 91 + 13) & 255);
   endfunction

   // ---------------- flash-side responder ----------------
   int         s_seed = 0;
   int         s_byte = 0;
   int         s_bit  = 0;
   logic [7:0] s_tx   = '0;
   logic [7:0] s_rx   = '0;
   logic [7:0] got[$];

   assign spi_miso = s_tx[7];

   always @(negedge spi_cs_n) begin
      s_byte = 0;
      s_bit  = 0;
      s_tx   = pat(s_seed, 0);
   end

   always @(posedge spi_sck) if (spi_cs_n === 1'b0) begin
      s_rx = {s_rx[6:0], spi_mosi};
      s_bit++;
      if (s_bit == 8) begin
         got.push_back(s_rx);
         s_bit = 0;
      end
   end

   always @(negedge spi_sck) if (spi_cs_n === 1'b0) begin
      if (s_bit == 0) begin
         s_byte++;
         s_tx = pat(s_seed, s_byte);
      end else
         s_tx = {s_tx[6:0], 1'b0};
   end

   // ---------------- cycle reference model ----------------
   int mcyc   = -1;
   int m_bits = 0;

   always @(posedge clk) begin
      if (!rst_n)
         mcyc = -1;
      else if (mcyc >= 0) begin
         mcyc++;
         if (mcyc >= (2 * m_bits + 1) * HALF) mcyc = -1;
      end else if (bus_we && bus_addr == A_CTRL && bus_wdata[0]) begin
         mcyc   = 0;
         m_bits = 8 * (1 + int'(bus_wdata[4:3]) + int'(bus_wdata[2:1]));
      end
   end

   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         check("R7", "cs_n", spi_cs_n, (mcyc < 0));
         check("R7", "sck", spi_sck,
               (mcyc >= 0) && (mcyc < 2 * m_bits * HALF) && (((mcyc / HALF) % 2) == 1));
         if (!bus_we && bus_addr == A_CTRL)
            check("R3", "busy bit", bus_rdata[0], (mcyc >= 0));
      end
   end

   // ---------------- bus tasks ----------------
   task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
      bus_addr  = A_CTRL;
   endtask

   task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_we   = 1'b0;
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [7:0] d;
      d = 8'h01;
      while (d[0] === 1'b1) reg_read(A_CTRL, d);
      bus_addr = A_CTRL;
      repeat (4) @(negedge clk);
   endtask

   logic [7:0] exp_rd[3];

   task automatic check_readback(input string req);
      logic [7:0] d;
      for (int i = 0; i < 3; i++) begin
         reg_read(8'h67 + 8'(i), d);
         check(req, $sformatf("readback slot %0d", i), d, exp_rd[i]);
      end
   endtask

   task automatic run_cmd(input logic [7:0] ctrl, input logic [7:0] opc,
                          input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2, input int seed);
      logic [7:0] wb[3];
      logic [7:0] d;
      int w;
      int r;
      wb[0] = b0; wb[1] = b1; wb[2] = b2;
      w = int'(ctrl[4:3]);
      r = int'(ctrl[2:1]);
      s_seed = seed;
      got.delete();
      reg_write(A_CTRL, ctrl & 8'hFE);
      reg_write(8'h61, opc);
      for (int i = 0; i < w; i++) reg_write(8'h64 + 8'(i), wb[i]);
      reg_write(A_CTRL, ctrl | 8'h01);
      wait_idle();
      // R6: frame length in bytes follows the counts exactly
      check("R6", "frame bytes", got.size(), 1 + w + r);
      if (got.size() == 1 + w + r) begin
         check("R4", "opcode on mosi", got[0], opc);
         for (int i = 0; i < w; i++)
            check("R4", $sformatf("write byte %0d", i), got[1 + i], wb[i]);
         for (int i = 0; i < r; i++)
            check("R4", "idle mosi in response", got[1 + w + i], 8'h00);
      end
      for (int i = 0; i < r; i++) exp_rd[i] = pat(seed, 1 + w + i);
      check_readback(r == 0 ? "R6" : "R5");
      reg_read(A_CTRL, d);
      check("R2", "control readback", d, ctrl & 8'hFE);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      logic [7:0] d;
      rst_n     = 1'b0;
      bus_addr  = A_CTRL;
      bus_we    = 1'b0;
      bus_wdata = '0;
      for (int i = 0; i < 3; i++) exp_rd[i] = 8'h00;
      repeat (5) @(negedge clk);
      check("R1", "cs_n in reset", spi_cs_n, 1'b1);
      check("R1", "sck in reset", spi_sck, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int a = 8'h60; a <= 8'h69; a++) begin
         reg_read(8'(a), d);
         check("R1", $sformatf("reg %0h after reset", a), d, 8'h00);
      end

      // read identification: class 010, 0 write, 3 read
      run_cmd(8'h46, 8'h9F, 8'h00, 8'h00, 8'h00, 1);
      // status-register write: class 011, 1 write, 0 read
      run_cmd(8'h68, 8'h01, 8'h5A, 8'h00, 8'h00, 2);
      // sector erase: class 101, 3 write, 0 read
      run_cmd(8'hB8, 8'h20, 8'h12, 8'h34, 8'h56, 3);

      // data read with 3 address bytes and 3 responses, poked while busy
      s_seed = 4;
      got.delete();
      reg_write(A_CTRL, 8'h5E);
      reg_write(8'h61, 8'h03);
      reg_write(8'h64, 8'hA1);
      reg_write(8'h65, 8'hB2);
      reg_write(8'h66, 8'hC3);
      reg_write(A_CTRL, 8'h5F);
      reg_read(A_CTRL, d);
      check("R8", "live busy with class bits", d, 8'h5F);
      reg_write(8'h61, 8'hEE);
      reg_write(A_CTRL, 8'h00);
      reg_write(8'h64, 8'h77);
      reg_write(A_CTRL, 8'h47);
      wait_idle();
      repeat (20) @(negedge clk);
      check("R8", "no second frame", got.size(), 7);
      check("R4", "opcode on mosi", got[0], 8'h03);
      check("R4", "address byte 0", got[1], 8'hA1);
      check("R4", "address byte 2", got[3], 8'hC3);
      reg_read(8'h61, d);
      check("R8", "opcode kept", d, 8'h03);
      reg_read(8'h64, d);
      check("R8", "write slot kept", d, 8'hA1);
      reg_read(A_CTRL, d);
      check("R8", "control kept", d, 8'h5E);
      for (int i = 0; i < 3; i++) exp_rd[i] = pat(4, 4 + i);
      check_readback("R5");

      // single response byte: only the first slot changes
      run_cmd(8'h42, 8'h05, 8'h00, 8'h00, 8'h00, 5);

      // read-only slots and unused addresses
      reg_write(8'h67, 8'hFF);
      reg_write(8'h69, 8'h3C);
      check_readback("R9");
      reg_write(8'h62, 8'h99);
      reg_read(8'h62, d);
      check("R9", "unused offset 2", d, 8'h00);
      reg_read(8'h63, d);
      check("R9", "unused offset 3", d, 8'h00);
      reg_read(8'h50, d);
      check("R9", "outside window", d, 8'h00);
      reg_read(8'h6A, d);
      check("R9", "past window", d, 8'h00);

      repeat (4) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL R3 watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule